// File: doc/BRIEF.md
# Outstanding Miss Request Tracker

This block sits between a processor-side load/store port and the request queue of a cache controller. It holds every memory request that is still in flight, keyed by the cache-line address. Loads and instruction fetches go into a read table. Stores and read-modify-write operations go into a write table. Each table is a small fully associative lookup of `ENTRIES` slots.

A new request is taken only when all of the following hold:
- there is room under the global in-flight limit and in its own table;
- its line is not already pending in either table;
- its byte span fits inside one line;
- the single issue register is free.

Each accepted request gets a unique ID. It is then presented on the issue port, translated into the controller's type and mode encoding, together with a delay chosen by access class.

A completion names a line and says whether it is a read or a write. It retires the matching entry and returns the ID and the measured latency. A completion that matches nothing raises an error pulse. A watchdog runs while requests are pending. Every `THRESH` cycles it inspects the ages of all entries and sets a sticky deadlock flag if any entry has waited `THRESH` cycles or longer.

Top module: `miss_tracker`

## Requirements
- R1: Request kinds are coded 0 load, 1 fetch, 2 store, 3 read-modify-write. Kinds 2 and 3 occupy the write table and are retired only by a completion with `cpl_write`=1. Kinds 0 and 1 occupy the read table and are retired only by a completion with `cpl_write`=0.
- R2: `req_ready` is low whenever the number of pending requests equals `MAX_OUT`.
- R3: `req_ready` is low when the request's line (address bits above the line offset) is pending in either table.
- R4: `req_ready` is low when the table the request would go into has no free slot, even if the global count is below `MAX_OUT`.
- R5: `req_ready` is low when the address offset within the line plus `req_len` exceeds `LINE_BYTES`.
- R6: Accepted requests receive IDs 0, 1, 2, ... in acceptance order. Refused requests consume no ID.
- R7: In the cycle after acceptance, `iss_valid` is 1 and `iss_line` holds the line. `iss_kind` is coded 0 load, 1 store, 2 fetch, 3 atomic (from read-modify-write). `iss_super` is 1 only for mode 1 (supervisor); modes 0 (user) and 2 (device) both give 0.
- R8: `iss_delay` equals `IC_LAT` for fetches and `DC_LAT` for all other kinds.
- R9: A matching completion gives `rsp_valid`=1 in the next cycle, with the entry's ID and `rsp_lat` equal to the clock edges from the accept edge to the completion edge. The slot and its line become free.
- R10: A completion that matches no entry of its table gives `cpl_err`=1 in the next cycle, with no `rsp_valid`, and leaves all entries unchanged.
- R11: The internal pending count always equals the number of valid entries across both tables.
- R12: The watchdog arms on an acceptance while disarmed and then checks every `THRESH` cycles. `deadlock` becomes 1, and stays 1 until reset, when a check finds an entry aged `THRESH` or more. The watchdog disarms at a check that finds nothing pending.
- R13: While `iss_valid`=1 and `iss_ready`=0, the issue outputs hold and new requests are refused. Raising `iss_ready` frees the slot for a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request offered |
| req_ready | output | 1 | Request accepted this cycle (combinational) |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Byte count |
| req_kind | input | 2 | 0 load, 1 fetch, 2 store, 3 read-modify-write |
| req_mode | input | 2 | 0 user, 1 supervisor, 2 device |
| iss_valid | output | 1 | Issue register holds a request |
| iss_ready | input | 1 | Controller takes the issued request |
| iss_line | output | ADDR_W-log2(LINE_BYTES) | Line address |
| iss_kind | output | 2 | 0 load, 1 store, 2 fetch, 3 atomic |
| iss_super | output | 1 | Supervisor mode |
| iss_delay | output | LAT_W | Cache latency to apply |
| iss_id | output | ID_W | Request ID |
| cpl_valid | input | 1 | Completion present |
| cpl_write | input | 1 | Completion targets the write table |
| cpl_line | input | ADDR_W-log2(LINE_BYTES) | Completed line |
| rsp_valid | output | 1 | Entry retired |
| rsp_id | output | ID_W | ID of the retired request |
| rsp_lat | output | TIME_W | Cycles the request was pending |
| cpl_err | output | 1 | Completion matched nothing |
| deadlock | output | 1 | Sticky watchdog error |

## Verification
The bench builds the tracker with 4 slots per table, a global limit of 6, 16-byte lines, 16-bit addresses and a threshold of 20 cycles.

A limit below twice the table size makes both refusals reachable within a few requests: the global count limit with free table slots, and a full read table while the count is under the limit.

The short threshold brings within reach both a watchdog episode that disarms after a quick retirement and one that fires on a stuck entry, with the firing edge bracketed. Short lines put offset-plus-length overflow one small length away.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    RQ_LOAD  = 2'd0,
    RQ_FETCH = 2'd1,
    RQ_STORE = 2'd2,
    RQ_RMW   = 2'd3
  } rq_kind_e;

  typedef enum logic [1:0] {
    CT_LOAD   = 2'd0,
    CT_STORE  = 2'd1,
    CT_FETCH  = 2'd2,
    CT_ATOMIC = 2'd3
  } ct_kind_e;

  localparam logic [1:0] MODE_SUPER = 2'd1;

  function automatic ct_kind_e map_kind(input rq_kind_e k);
    case (k)
      RQ_LOAD:  map_kind = CT_LOAD;
      RQ_FETCH: map_kind = CT_FETCH;
      RQ_STORE: map_kind = CT_STORE;
      default:  map_kind = CT_ATOMIC;
    endcase
  endfunction
endpackage

// File: rtl/mt_table.sv
module mt_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 26,
  parameter int ID_W    = 16,
  parameter int TIME_W  = 16,
  parameter int THRESH  = 1000,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now,
  input  logic [TAG_W-1:0]  probe_tag,
  output logic              probe_hit,
  output logic              full,
  input  logic              ins_en,
  input  logic [ID_W-1:0]   ins_id,
  input  logic              ret_en,
  input  logic [TAG_W-1:0]  ret_tag,
  output logic              ret_hit,
  output logic [ID_W-1:0]   ret_id,
  output logic [TIME_W-1:0] ret_stamp,
  output logic              old_any,
  output logic [CNT_W-1:0]  valid_cnt
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [TIME_W-1:0] LIMIT = TIME_W'(THRESH);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [ID_W-1:0]    id_q    [ENTRIES];
  logic [TIME_W-1:0]  stamp_q [ENTRIES];

  logic [IDX_W-1:0]  free_idx, ret_idx;
  logic              found_free;
  logic [TIME_W-1:0] age;

  always_comb begin
    probe_hit  = 1'b0;
    ret_hit    = 1'b0;
    ret_id     = '0;
    ret_stamp  = '0;
    ret_idx    = '0;
    free_idx   = '0;
    found_free = 1'b0;
    old_any    = 1'b0;
    valid_cnt  = '0;
    age        = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      age = now - stamp_q[i];
      if (vld[i] && tag_q[i] == probe_tag) probe_hit = 1'b1;
      if (vld[i] && tag_q[i] == ret_tag) begin
        ret_hit   = 1'b1;
        ret_id    = id_q[i];
        ret_stamp = stamp_q[i];
        ret_idx   = IDX_W'(i);
      end
      if (!vld[i] && !found_free) begin
        found_free = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (vld[i] && age >= LIMIT) old_any = 1'b1;
      valid_cnt = valid_cnt + CNT_W'(vld[i]);
    end
    full = !found_free;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (ret_en && ret_hit) vld[ret_idx] <= 1'b0;
      if (ins_en) vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q[free_idx]   <= probe_tag;
      id_q[free_idx]    <= ins_id;
      stamp_q[free_idx] <= now;
    end
  end

  // R3: the owner never inserts a line that is pending or into a full table
  assert_no_dup_insert_R3: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> (!probe_hit && !full));
endmodule

// File: rtl/mt_watchdog.sv
module mt_watchdog #(
  parameter int THRESH = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_req,
  input  logic busy,
  input  logic stale,
  output logic armed,
  output logic deadlock
);
  localparam int TM_W = $clog2(THRESH + 1);
  localparam logic [TM_W-1:0] LAST = TM_W'(THRESH - 1);

  logic [TM_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      deadlock <= 1'b0;
      timer    <= '0;
    end else if (!armed) begin
      if (arm_req) begin
        armed <= 1'b1;
        timer <= '0;
      end
    end else if (timer == LAST) begin
      timer <= '0;
      if (stale) deadlock <= 1'b1;
      if (!busy && !arm_req) armed <= 1'b0;
    end else begin
      timer <= timer + 1'b1;
    end
  end
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import mt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 7,
  parameter int ENTRIES    = 8,
  parameter int MAX_OUT    = 12,
  parameter int THRESH     = 1000,
  parameter int ID_W       = 16,
  parameter int TIME_W     = 16,
  parameter int LAT_W      = 8,
  parameter int IC_LAT     = 2,
  parameter int DC_LAT     = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_mode,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [TAG_W-1:0]  iss_line,
  output logic [1:0]        iss_kind,
  output logic              iss_super,
  output logic [LAT_W-1:0]  iss_delay,
  output logic [ID_W-1:0]   iss_id,
  input  logic              cpl_valid,
  input  logic              cpl_write,
  input  logic [TAG_W-1:0]  cpl_line,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [TIME_W-1:0] rsp_lat,
  output logic              cpl_err,
  output logic              deadlock
);
  localparam int CNT_W = $clog2(2 * ENTRIES + 1);

  logic [TIME_W-1:0] now;
  logic [ID_W-1:0]   next_id;
  logic [CNT_W-1:0]  cnt_q;

  logic [TAG_W-1:0] line;
  logic [31:0]      span;
  logic             is_wr, len_ok, slot_free, accept, retire, hit;
  rq_kind_e         kind;

  logic              rd_hit, wr_hit, rd_full, wr_full, rd_old, wr_old;
  logic              rd_rhit, wr_rhit;
  logic [ID_W-1:0]   rd_rid, wr_rid;
  logic [TIME_W-1:0] rd_stamp, wr_stamp;
  logic [CNT_W-1:0]  rd_cnt, wr_cnt;
  logic              wd_armed;

  assign kind      = rq_kind_e'(req_kind);
  assign line      = req_addr[ADDR_W-1:OFF_W];
  assign span      = 32'(req_addr[OFF_W-1:0]) + 32'(req_len);
  assign is_wr     = (kind == RQ_STORE) || (kind == RQ_RMW);
  assign len_ok    = span <= 32'(LINE_BYTES);
  assign slot_free = !iss_valid || iss_ready;
  assign req_ready = slot_free && (cnt_q < CNT_W'(MAX_OUT)) && !rd_hit && !wr_hit
                   && (is_wr ? !wr_full : !rd_full) && len_ok;
  assign accept    = req_valid && req_ready;
  assign hit       = cpl_write ? wr_rhit : rd_rhit;
  assign retire    = cpl_valid && hit;

  for (genvar g = 0; g < 2; g++) begin : g_tab
    logic ins, ret, ph, fl, rh, od;
    logic [ID_W-1:0]   rid;
    logic [TIME_W-1:0] st;
    logic [CNT_W-1:0]  vc;
    assign ins = accept && (is_wr == (g == 1));
    assign ret = cpl_valid && (cpl_write == (g == 1));
    mt_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ID_W(ID_W), .TIME_W(TIME_W),
               .THRESH(THRESH), .CNT_W(CNT_W)) u_tab (
      .clk(clk), .rst(rst), .now(now), .probe_tag(line), .probe_hit(ph), .full(fl),
      .ins_en(ins), .ins_id(next_id), .ret_en(ret), .ret_tag(cpl_line),
      .ret_hit(rh), .ret_id(rid), .ret_stamp(st), .old_any(od), .valid_cnt(vc));
  end

  assign rd_hit = g_tab[0].ph;   assign wr_hit = g_tab[1].ph;
  assign rd_full = g_tab[0].fl;  assign wr_full = g_tab[1].fl;
  assign rd_rhit = g_tab[0].rh;  assign wr_rhit = g_tab[1].rh;
  assign rd_rid = g_tab[0].rid;  assign wr_rid = g_tab[1].rid;
  assign rd_stamp = g_tab[0].st; assign wr_stamp = g_tab[1].st;
  assign rd_old = g_tab[0].od;   assign wr_old = g_tab[1].od;
  assign rd_cnt = g_tab[0].vc;   assign wr_cnt = g_tab[1].vc;

  mt_watchdog #(.THRESH(THRESH)) u_wd (
    .clk(clk), .rst(rst), .arm_req(accept), .busy(cnt_q != '0),
    .stale(rd_old || wr_old), .armed(wd_armed), .deadlock(deadlock));

  always_ff @(posedge clk) begin
    if (rst) begin
      now       <= '0;
      next_id   <= '0;
      cnt_q     <= '0;
      iss_valid <= 1'b0;
      rsp_valid <= 1'b0;
      cpl_err   <= 1'b0;
    end else begin
      now       <= now + 1'b1;
      cnt_q     <= cnt_q + CNT_W'(accept) - CNT_W'(retire);
      rsp_valid <= retire;
      cpl_err   <= cpl_valid && !hit;
      if (accept) begin
        next_id   <= next_id + 1'b1;
        iss_valid <= 1'b1;
      end else if (iss_ready) begin
        iss_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      iss_line  <= line;
      iss_kind  <= map_kind(kind);
      iss_super <= (req_mode == MODE_SUPER);
      iss_delay <= (kind == RQ_FETCH) ? LAT_W'(IC_LAT) : LAT_W'(DC_LAT);
      iss_id    <= next_id;
    end
    if (retire) begin
      rsp_id  <= cpl_write ? wr_rid : rd_rid;
      rsp_lat <= now - (cpl_write ? wr_stamp : rd_stamp);
    end
  end

  assert_count_matches_tables_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_q == CNT_W'(rd_cnt + wr_cnt));
  assert_count_within_limit_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_OUT));
  assert_issue_holds_R13: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_id) && $stable(iss_line)));
  assert_armed_while_pending_R12: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> wd_armed);
  assert_rsp_err_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && cpl_err));
endmodule

// File: tb/miss_tracker_test.sv
module miss_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int TH = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, iss_ready = 1'b1, cpl_valid = 1'b0, cpl_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic [1:0]  req_kind = '0, req_mode = '0;
  logic [11:0] cpl_line = '0;
  logic        req_ready, iss_valid, iss_super, rsp_valid, cpl_err, deadlock;
  logic [11:0] iss_line, rsp_lat;
  logic [1:0]  iss_kind;
  logic [3:0]  iss_delay;
  logic [7:0]  iss_id, rsp_id;

  int n_chk = 0, n_fail = 0, cyc = 0, exp_id = 0;
  int acc_cyc [0:31];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc++;

  miss_tracker #(.ADDR_W(16), .LINE_BYTES(16), .LEN_W(5), .ENTRIES(4), .MAX_OUT(6),
                 .THRESH(TH), .ID_W(8), .TIME_W(12), .LAT_W(4), .IC_LAT(2), .DC_LAT(5)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_kind(req_kind), .req_mode(req_mode), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_line(iss_line), .iss_kind(iss_kind), .iss_super(iss_super),
    .iss_delay(iss_delay), .iss_id(iss_id), .cpl_valid(cpl_valid), .cpl_write(cpl_write),
    .cpl_line(cpl_line), .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_lat(rsp_lat),
    .cpl_err(cpl_err), .deadlock(deadlock));

  // vector: kind, mode, addr, len, expected accept
  localparam logic [25:0] VEC [10] = '{
    {2'd0, 2'd0, 16'h0100, 5'd4,  1'b1},
    {2'd1, 2'd1, 16'h0204, 5'd8,  1'b1},
    {2'd2, 2'd2, 16'h0308, 5'd8,  1'b1},
    {2'd3, 2'd0, 16'h0400, 5'd16, 1'b1},
    {2'd0, 2'd0, 16'h0104, 5'd4,  1'b0},
    {2'd0, 2'd1, 16'h030C, 5'd4,  1'b0},
    {2'd2, 2'd0, 16'h050C, 5'd8,  1'b0},
    {2'd0, 2'd0, 16'h0600, 5'd4,  1'b1},
    {2'd0, 2'd0, 16'h0700, 5'd4,  1'b1},
    {2'd2, 2'd0, 16'h0800, 5'd4,  1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] exp_kind(input logic [1:0] k);
    case (k)
      2'd0: exp_kind = 2'd0;
      2'd1: exp_kind = 2'd2;
      2'd2: exp_kind = 2'd1;
      default: exp_kind = 2'd3;
    endcase
  endfunction

  task automatic try_req(input logic [1:0] k, input logic [1:0] m, input logic [15:0] a,
                         input logic [4:0] l, input logic ok, input string tag);
    req_valid = 1'b1; req_kind = k; req_mode = m; req_addr = a; req_len = l;
    #1;
    chk({tag, " req_ready"}, 32'(req_ready), 32'(ok));
    step();
    req_valid = 1'b0;
    if (ok) begin
      chk("R7 iss_valid", 32'(iss_valid), 1);
      chk("R6 iss_id", 32'(iss_id), 32'(exp_id & 8'hFF));
      chk("R7 iss_line", 32'(iss_line), 32'(a[15:4]));
      chk("R7 iss_kind", 32'(iss_kind), 32'(exp_kind(k)));
      chk("R7 iss_super", 32'(iss_super), 32'(m == 2'd1));
      chk("R8 iss_delay", 32'(iss_delay), (k == 2'd1) ? 2 : 5);
      acc_cyc[exp_id] = cyc;
      exp_id++;
    end
  endtask

  task automatic complete(input logic w, input logic [11:0] ln, input logic ok,
                          input int id, input string tag);
    cpl_valid = 1'b1; cpl_write = w; cpl_line = ln;
    step();
    cpl_valid = 1'b0;
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'(ok));
    chk({tag, " cpl_err"}, 32'(cpl_err), 32'(!ok));
    if (ok) begin
      chk({tag, " rsp_id"}, 32'(rsp_id), 32'(id));
      chk({tag, " rsp_lat"}, 32'(rsp_lat), 32'(cyc - acc_cyc[id]));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    exp_id = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL timeout (R12 run) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("reset iss_valid", 32'(iss_valid), 0);
    chk("reset rsp_valid R9", 32'(rsp_valid), 0);
    chk("reset cpl_err R10", 32'(cpl_err), 0);
    chk("reset deadlock R12", 32'(deadlock), 0);

    // table walk: R2 R3 R5 R6 R7 R8
    for (int k = 0; k < 10; k++) begin
      logic [25:0] v;
      v = VEC[k];
      try_req(v[25:24], v[23:22], v[21:6], v[5:1], v[0], $sformatf("vec%0d R2 R3 R5", k));
    end

    complete(1'b1, 12'h020, 1'b0, 0, "R10 write cpl on read line");
    complete(1'b0, 12'h010, 1'b1, 0, "R9 R1 load retire");
    try_req(2'd0, 2'd0, 16'h0104, 5'd4, 1'b1, "R9 line freed");
    complete(1'b0, 12'h010, 1'b1, 6, "R9 retire again");
    try_req(2'd2, 2'd0, 16'h0800, 5'd4, 1'b1, "R2 R11 room after retire");
    complete(1'b1, 12'h030, 1'b1, 2, "R1 store in write table");
    try_req(2'd0, 2'd0, 16'h0900, 5'd4, 1'b1, "R4 fill read table");
    complete(1'b1, 12'h040, 1'b1, 3, "R1 rmw in write table");
    try_req(2'd0, 2'd0, 16'h0A00, 5'd4, 1'b0, "R4 read table full");
    try_req(2'd2, 2'd0, 16'h0A00, 5'd4, 1'b1, "R4 write table has room");
    complete(1'b0, 12'h020, 1'b1, 1, "R1 fetch in read table");
    complete(1'b0, 12'h060, 1'b1, 4, "R9 load retire");

    iss_ready = 1'b0;
    try_req(2'd0, 2'd0, 16'h0B00, 5'd4, 1'b1, "R13 accept into slot");
    try_req(2'd0, 2'd0, 16'h0C00, 5'd4, 1'b0, "R13 slot busy");
    chk("R13 iss_valid held", 32'(iss_valid), 1);
    chk("R13 iss_id held", 32'(iss_id), 32'(exp_id - 1));
    iss_ready = 1'b1;
    try_req(2'd0, 2'd0, 16'h0C00, 5'd4, 1'b1, "R13 slot frees same cycle");

    // watchdog episodes R12
    do_reset();
    try_req(2'd0, 2'd0, 16'h0100, 5'd4, 1'b1, "R12 quick req");
    repeat (9) step();
    complete(1'b0, 12'h010, 1'b1, 0, "R12 quick retire");
    repeat (45) step();
    chk("R12 no deadlock after disarm", 32'(deadlock), 0);
    try_req(2'd0, 2'd0, 16'h0200, 5'd4, 1'b1, "R12 stuck req");
    repeat (TH - 2) step();
    chk("R12 not yet aged", 32'(deadlock), 0);
    repeat (2) step();
    chk("R12 deadlock raised", 32'(deadlock), 1);
    repeat (30) step();
    chk("R12 deadlock sticky", 32'(deadlock), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule